// File: doc/BRIEF.md
# Resolution-Aware Window Comparator Watchdog

This block watches the stream of results coming out of an analog-to-digital converter and raises a sticky alarm whenever a result falls outside a programmable window. Each result arrives as a one-cycle valid strobe carrying a data word and the number of the channel it came from. The converter's current resolution (12, 10, 8 or 6 bits) is an input. Both results and thresholds are expressed in units of that resolution. Before comparison, all three are left-aligned to a common 12-bit scale.

Software programs the window bounds, the watching mode, the watched channel and an interrupt enable through a simple register-write port. The watching mode is off, all channels, or one selected channel. The alarm flag stays set until software writes 1 to a clear location. The interrupt line follows the flag, gated by the enable.

Top module: `win_watchdog`

## Requirements
- R1: After a synchronous active-low reset, the alarm flag and the interrupt output are both 0, and the watching mode is off.
- R2: With the mode field at 0 (off) or 3 (reserved), no result sets the flag.
- R3: With the mode field at 1 (all channels), a valid result on any channel that is strictly above the high bound sets the flag. The flag is visible on the edge after the result strobe.
- R4: A result strictly below the low bound sets the flag. A result equal to either bound does not set it.
- R5: With the mode field at 2 (single channel), only results whose channel number equals the selected channel are compared. Results on other channels leave the flag unchanged.
- R6: Thresholds and results are masked to the resolution width and then shifted left by 0, 2, 4 or 6 bits. The resolution code is 0=12, 1=10, 2=8, 3=6 bits, and zeros fill the low bits. Bits above the resolution width in a threshold or a result therefore have no effect.
- R7: The flag is sticky. It is cleared only by a write to address 2 with data bit 0 set. A write of 0 to that bit, and in-window results, leave the flag set.
- R8: When a set and a clear fall in the same cycle, the set wins and the flag stays 1.
- R9: The interrupt output equals the flag ANDed with the interrupt enable.
- R10: Register layout:
  - Address 0 holds the bounds: high bound in bits 27:16, low bound in bits 11:0.
  - Address 1 holds the configuration: mode in bits 1:0, selected channel in bits 12:8, interrupt enable in bit 16.
- R11: When the valid strobe is low, the data and channel inputs have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_sel | input | 2 | Current resolution code (0=12, 1=10, 2=8, 3=6 bits) |
| rv_valid | input | 1 | Result valid strobe |
| rv_data | input | 12 | Result word, right-aligned in resolution units |
| rv_chan | input | 5 | Channel number of the result |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| oow_flag | output | 1 | Sticky out-of-window flag |
| irq | output | 1 | Interrupt request |

## Verification
An out-of-window result and a write-1 clear of the flag can arrive in the same cycle. The bench drives the result strobe and the clear write on the same falling edge. It then samples the flag on the following falling edge and expects it still set. The bench then repeats the collision with an in-window result and expects the flag cleared. This shows that the clear path works on its own and that only a real set overrides it.

// File: rtl/wwd_pkg.sv
// Shared types and constants for the window comparator watchdog.
// Assumes 12-bit full-scale results and a 2-bit resolution code.
package wwd_pkg;
    localparam int SAMPLE_W = 12;
    localparam int RES_W    = 2;
    localparam int CHAN_W   = 5;
    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 2;

    // register addresses
    localparam logic [ADDR_W-1:0] ADR_BOUNDS = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CONFIG = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CLEAR  = 2'd2;

    // field positions
    localparam int HI_LSB   = 16;
    localparam int LO_LSB   = 0;
    localparam int MODE_LSB = 0;
    localparam int CHAN_LSB = 8;
    localparam int IEN_BIT  = 16;
    localparam int CLR_BIT  = 0;

    typedef enum logic [1:0] {
        WM_OFF = 2'd0,
        WM_ALL = 2'd1,
        WM_ONE = 2'd2,
        WM_RSV = 2'd3
    } wmode_t;
endpackage

// File: rtl/wwd_regs.sv
// Configuration registers of the watchdog: window bounds, mode,
// selected channel and interrupt enable, plus a decoded clear request.
// Assumes single-cycle write strobes; writes to unused addresses are dropped.
module wwd_regs
    import wwd_pkg::*;
#(
    parameter int DW  = SAMPLE_W,
    parameter int CW  = CHAN_W,
    parameter int BW  = BUS_W,
    parameter int AW  = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [BW-1:0] wr_data,
    output logic [DW-1:0] thr_hi,
    output logic [DW-1:0] thr_lo,
    output wmode_t        mode,
    output logic [CW-1:0] sel_chan,
    output logic          irq_en,
    output logic          clr_req
);
    localparam logic [DW-1:0] HI_RST = {DW{1'b1}};

    // Bounds register: high and low thresholds in resolution units.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_hi <= HI_RST;
            thr_lo <= '0;
        end else if (wr_en && wr_addr == ADR_BOUNDS) begin
            thr_hi <= wr_data[HI_LSB +: DW];
            thr_lo <= wr_data[LO_LSB +: DW];
        end
    end

    // Configuration register: mode, watched channel, interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= WM_OFF;
            sel_chan <= '0;
            irq_en   <= 1'b0;
        end else if (wr_en && wr_addr == ADR_CONFIG) begin
            mode     <= wmode_t'(wr_data[MODE_LSB +: 2]);
            sel_chan <= wr_data[CHAN_LSB +: CW];
            irq_en   <= wr_data[IEN_BIT];
        end
    end

    // Clear request: write of 1 to the clear bit at the clear address.
    always_comb begin
        clr_req = wr_en && (wr_addr == ADR_CLEAR) && wr_data[CLR_BIT];
    end
endmodule

// File: rtl/wwd_align.sv
// Left-aligns a value given in resolution units onto the full-scale grid.
// Bits above the resolution width are masked, low bits are zero-filled.
// Assumes each resolution step removes two bits.
module wwd_align #(
    parameter int DW = 12,
    parameter int RW = 2
) (
    input  logic [DW-1:0] raw,
    input  logic [RW-1:0] res,
    output logic [DW-1:0] aligned
);
    localparam int STEP = 2;

    int            shamt;
    logic [DW-1:0] keep;

    // Mask to resolution width, then shift up to the top bit.
    always_comb begin
        shamt   = int'(res) * STEP;
        keep    = {DW{1'b1}} >> shamt;
        aligned = (raw & keep) << shamt;
    end
endmodule

// File: rtl/wwd_window.sv
// Decides whether a valid result is watched and lies outside the window.
// Assumes aligned operands; bounds are inclusive (equal is inside).
module wwd_window
    import wwd_pkg::*;
#(
    parameter int DW = SAMPLE_W,
    parameter int CW = CHAN_W
) (
    input  logic          valid,
    input  logic [CW-1:0] chan,
    input  logic [DW-1:0] data_al,
    input  logic [DW-1:0] hi_al,
    input  logic [DW-1:0] lo_al,
    input  wmode_t        mode,
    input  logic [CW-1:0] sel_chan,
    output logic          hit
);
    logic watched;
    logic outside;

    // Channel filter according to watching mode.
    always_comb begin
        unique case (mode)
            WM_ALL:  watched = 1'b1;
            WM_ONE:  watched = (chan == sel_chan);
            default: watched = 1'b0;
        endcase
    end

    // Strict comparison against both bounds.
    always_comb begin
        outside = (data_al > hi_al) || (data_al < lo_al);
        hit     = valid && watched && outside;
    end
endmodule

// File: rtl/win_watchdog.sv
// Top of the window comparator watchdog: aligns result and bounds to the
// full-scale grid, compares, and holds a sticky flag with interrupt gating.
// Assumes res_sel is stable while results are being produced.
module win_watchdog
    import wwd_pkg::*;
#(
    parameter int DW = SAMPLE_W,
    parameter int RW = RES_W,
    parameter int CW = CHAN_W,
    parameter int BW = BUS_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] res_sel,
    input  logic          rv_valid,
    input  logic [DW-1:0] rv_data,
    input  logic [CW-1:0] rv_chan,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [BW-1:0] wr_data,
    output logic          oow_flag,
    output logic          irq
);
    localparam int N_OPS  = 3;
    localparam int OP_DAT = 0;
    localparam int OP_HI  = 1;
    localparam int OP_LO  = 2;

    logic [DW-1:0] thr_hi, thr_lo;
    wmode_t        cfg_mode;
    logic [CW-1:0] cfg_sel;
    logic          cfg_irq_en;
    logic          clr_req;
    logic          win_hit;
    logic [DW-1:0] op_raw [N_OPS];
    logic [DW-1:0] op_al  [N_OPS];

    wwd_regs #(.DW(DW), .CW(CW), .BW(BW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .thr_hi   (thr_hi),
        .thr_lo   (thr_lo),
        .mode     (cfg_mode),
        .sel_chan (cfg_sel),
        .irq_en   (cfg_irq_en),
        .clr_req  (clr_req)
    );

    // Gather the three operands that need alignment.
    always_comb begin
        op_raw[OP_DAT] = rv_data;
        op_raw[OP_HI]  = thr_hi;
        op_raw[OP_LO]  = thr_lo;
    end

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_align
        wwd_align #(.DW(DW), .RW(RW)) u_align (
            .raw     (op_raw[gi]),
            .res     (res_sel),
            .aligned (op_al[gi])
        );
    end

    wwd_window #(.DW(DW), .CW(CW)) u_win (
        .valid    (rv_valid),
        .chan     (rv_chan),
        .data_al  (op_al[OP_DAT]),
        .hi_al    (op_al[OP_HI]),
        .lo_al    (op_al[OP_LO]),
        .mode     (cfg_mode),
        .sel_chan (cfg_sel),
        .hit      (win_hit)
    );

    // Sticky flag: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       oow_flag <= 1'b0;
        else if (win_hit) oow_flag <= 1'b1;
        else if (clr_req) oow_flag <= 1'b0;
    end

    // Interrupt request gated by enable.
    always_comb begin
        irq = oow_flag && cfg_irq_en;
    end
endmodule

// File: rtl/wwd_checker.sv
// Temporal checks for the window watchdog, bound into the top module.
module wwd_checker #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rv_valid,
    input logic [CW-1:0] rv_chan,
    input logic          oow_flag,
    input logic          irq,
    input logic [1:0]    cfg_mode,
    input logic [CW-1:0] cfg_sel,
    input logic          cfg_irq_en,
    input logic          clr_req,
    input logic          win_hit
);
    a_r2_off_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0 || cfg_mode == 2'd3) |=> !$rose(oow_flag));

    a_r5_other_chan_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd2 && rv_chan != cfg_sel) |=> !$rose(oow_flag));

    a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (oow_flag && !clr_req) |=> oow_flag);

    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && clr_req) |=> oow_flag);

    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (oow_flag && cfg_irq_en));

    a_r11_rise_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oow_flag) |-> $past(rv_valid));
endmodule

bind win_watchdog wwd_checker #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rv_valid   (rv_valid),
    .rv_chan    (rv_chan),
    .oow_flag   (oow_flag),
    .irq        (irq),
    .cfg_mode   (cfg_mode),
    .cfg_sel    (cfg_sel),
    .cfg_irq_en (cfg_irq_en),
    .clr_req    (clr_req),
    .win_hit    (win_hit)
);

// File: tb/win_watchdog_test.sv
module win_watchdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  res_sel = 2'd0;
    logic        rv_valid = 1'b0;
    logic [11:0] rv_data = '0;
    logic [4:0]  rv_chan = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        oow_flag, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    win_watchdog uut (
        .clk(clk), .rst_n(rst_n), .res_sel(res_sel),
        .rv_valid(rv_valid), .rv_data(rv_data), .rv_chan(rv_chan),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .oow_flag(oow_flag), .irq(irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cfgw(input logic [1:0] m, input logic [4:0] ch, input logic ie);
        logic [31:0] w = '0;
        w[1:0] = m; w[12:8] = ch; w[16] = ie;
        return w;
    endfunction

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bounds(input logic [11:0] hi, input logic [11:0] lo);
        write_reg(2'd0, {4'h0, hi, 4'h0, lo});
    endtask

    task automatic send(input logic [4:0] ch, input logic [11:0] d);
        @(negedge clk); rv_valid = 1'b1; rv_chan = ch; rv_data = d;
        @(negedge clk); rv_valid = 1'b0;
    endtask

    task automatic clear_flag();
        write_reg(2'd2, 32'h1);
    endtask

    task automatic t_reset();
        check("R1 flag after reset", oow_flag, 1'b0);
        check("R1 irq after reset", irq, 1'b0);
        send(5'd1, 12'hFFF);
        check("R1 mode off after reset", oow_flag, 1'b0);
    endtask

    task automatic t_off();
        bounds(12'h800, 12'h100);
        write_reg(2'd1, cfgw(2'd0, 5'd0, 1'b0));
        send(5'd3, 12'hFFF);
        check("R2 off mode high", oow_flag, 1'b0);
        write_reg(2'd1, cfgw(2'd3, 5'd0, 1'b0));
        send(5'd3, 12'h000);
        check("R2 reserved mode low", oow_flag, 1'b0);
    endtask

    task automatic t_all_high();
        write_reg(2'd1, cfgw(2'd1, 5'd0, 1'b0));
        send(5'd7, 12'h801);
        check("R3 above high any channel", oow_flag, 1'b1);
        clear_flag();
        check("R7 cleared", oow_flag, 1'b0);
    endtask

    task automatic t_edges();
        send(5'd2, 12'h800);
        check("R4 equal high inside (R10 layout)", oow_flag, 1'b0);
        send(5'd2, 12'h100);
        check("R4 equal low inside (R10 layout)", oow_flag, 1'b0);
        send(5'd2, 12'h0FF);
        check("R4 below low", oow_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_single();
        write_reg(2'd1, cfgw(2'd2, 5'd4, 1'b0));
        send(5'd5, 12'hFFF);
        check("R5 other channel ignored", oow_flag, 1'b0);
        send(5'd4, 12'hFFF);
        check("R5 selected channel", oow_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_resolution();
        write_reg(2'd1, cfgw(2'd1, 5'd0, 1'b0));
        @(negedge clk); res_sel = 2'd2;
        bounds(12'hF80, 12'h010);
        send(5'd0, 12'h080);
        check("R6 8-bit equal high masked", oow_flag, 1'b0);
        send(5'd0, 12'hF40);
        check("R6 8-bit data upper bits ignored", oow_flag, 1'b0);
        send(5'd0, 12'h081);
        check("R6 8-bit above high", oow_flag, 1'b1);
        clear_flag();
        send(5'd0, 12'h00F);
        check("R6 8-bit below low", oow_flag, 1'b1);
        clear_flag();
        @(negedge clk); res_sel = 2'd3;
        bounds(12'h020, 12'h008);
        send(5'd0, 12'h020);
        check("R6 6-bit equal high", oow_flag, 1'b0);
        send(5'd0, 12'h021);
        check("R6 6-bit above high", oow_flag, 1'b1);
        clear_flag();
        @(negedge clk); res_sel = 2'd1;
        bounds(12'h200, 12'h000);
        send(5'd0, 12'h3FF);
        check("R6 10-bit above high", oow_flag, 1'b1);
        clear_flag();
        @(negedge clk); res_sel = 2'd0;
        bounds(12'h800, 12'h100);
    endtask

    task automatic t_sticky();
        send(5'd1, 12'hFFF);
        send(5'd1, 12'h400);
        check("R7 stays after in-window", oow_flag, 1'b1);
        write_reg(2'd2, 32'h0);
        check("R7 write 0 no clear", oow_flag, 1'b1);
        write_reg(2'd3, 32'hFFFF_FFFF);
        check("R7 other address no clear", oow_flag, 1'b1);
        clear_flag();
        check("R7 write 1 clears", oow_flag, 1'b0);
    endtask

    task automatic t_collide();
        send(5'd1, 12'hFFF);
        @(negedge clk);
        rv_valid = 1'b1; rv_chan = 5'd1; rv_data = 12'hFFF;
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h1;
        @(negedge clk);
        rv_valid = 1'b0; wr_en = 1'b0;
        check("R8 set beats clear", oow_flag, 1'b1);
        @(negedge clk);
        rv_valid = 1'b1; rv_data = 12'h400;
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h1;
        @(negedge clk);
        rv_valid = 1'b0; wr_en = 1'b0;
        check("R8 in-window with clear clears", oow_flag, 1'b0);
    endtask

    task automatic t_irq();
        send(5'd1, 12'hFFF);
        check("R9 irq masked", irq, 1'b0);
        write_reg(2'd1, cfgw(2'd1, 5'd0, 1'b1));
        check("R9 irq enabled", irq, 1'b1);
        clear_flag();
        check("R9 irq after clear", irq, 1'b0);
    endtask

    task automatic t_novalid();
        @(negedge clk); rv_valid = 1'b0; rv_chan = 5'd0; rv_data = 12'hFFF;
        @(negedge clk);
        @(negedge clk);
        check("R11 no strobe no effect", oow_flag, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off();
        t_all_high();
        t_edges();
        t_single();
        t_resolution();
        write_reg(2'd1, cfgw(2'd1, 5'd0, 1'b0));
        t_sticky();
        t_collide();
        t_irq();
        t_novalid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule